// File: doc/BRIEF.md
# Fractional Predivider Clock Generator

This block produces a divided output clock from one of three reference rates. Each reference arrives as a single-cycle tick on the block's system clock. Two select bits in the configuration word pick the reference. A predivider then divides it by 2, 2.5 or 3, and a 7-bit integer divider divides the result further. The output is a registered square-ish wave. Its period is the predivider ratio times the integer divisor, measured in ticks of the chosen reference.

Software writes one configuration word. It holds the divisor, the predivider code, both select bits and an enable. Every write replaces the whole word, but the running divider takes the new settings only when an output period ends, so a reconfiguration never cuts a pulse short. Clearing the enable lets the current high phase finish before the output parks low and the counters clear. A configuration with predivider code 0 or a divisor below 2 keeps the output low.

Top module: `frac_clkgen`

## Requirements
- R1: Source choice comes from two bits. With `esel`=0 the divider counts `ref_tick[0]`, whatever `psel` is. With `esel`=1 and `psel`=0 it counts `ref_tick[1]`. With `esel`=1 and `psel`=1 it counts `ref_tick[2]`. Ticks on a reference that is not selected have no effect on the output.
- R2: Predivider code 1 divides the selected ticks by 2 and code 3 divides them by 3. Code 2 divides by 2.5 by alternating periods of 2 and 3 ticks, so two consecutive output periods always total 5 × divisor ticks.
- R3: The integer divisor's legal range is 2 to 127. The output period is the predivider ratio × divisor ticks of the selected reference; for ratio 2.5 with an odd divisor, this holds over each pair of periods.
- R4: The output is high for the first floor(divisor/2) predivider periods of each output period and low for the rest.
- R5: While the stored word is enabled but has predivider code 0 or a divisor below 2, the output stays low.
- R6: The configuration word is 12 bits. Divisor is in [6:0], predivider code in [8:7], `psel` in [9], `esel` in [10] and enable in [11]. A write replaces all fields at once.
- R7: A new word written while running takes effect only at the next output period boundary. The period in progress completes with its old high time and old length.
- R8: After the enable is cleared, a high output finishes its normal high phase and then stays low. The next enable starts from cleared counters, so its first high phase has the full nominal width.
- R9: After reset the output is low and the stored word is all zero, which means disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 3 | One-cycle ticks of the three reference rates |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 12 | Configuration word (layout in R6) |
| clk_out | output | 1 | Divided output clock |

## Verification
The hardest case to reach is a reconfiguration that arrives partway through a long output period. The old period must still finish at its old length. This is set up by selecting a 300-tick period, writing a 4-tick configuration a few cycles after a rising edge, and timing the following fall and rise. The 2.5 ratio with odd divisors is also awkward, because single periods differ in length. The bench therefore runs each reference at a different tick spacing and measures pairs of periods, which both separates the three sources and cancels the alternation.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
    localparam int DIV_W   = 7;
    localparam int PRE_W   = 2;
    localparam int NUM_REF = 3;
    localparam int CFG_W   = 1 + 1 + 1 + PRE_W + DIV_W;
    localparam int MIN_DIV = 2;

    // Packed so a cast of the written word lands every field in place:
    // en[11] esel[10] psel[9] pdiv[8:7] div[6:0]
    typedef struct packed {
        logic             en;
        logic             esel;
        logic             psel;
        logic [PRE_W-1:0] pdiv;
        logic [DIV_W-1:0] div;
    } clk_cfg_t;

    function automatic logic cfg_valid(input clk_cfg_t c);
        return c.en && (c.pdiv != '0) && (c.div >= DIV_W'(MIN_DIV));
    endfunction
endpackage

// File: rtl/fcg_prediv.sv
module fcg_prediv
    import fcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [PRE_W-1:0] code,
    output logic             tick
);
    localparam int CNT_W = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } pre_st_t;

    pre_st_t          s_q, s_d;
    logic [CNT_W-1:0] last;

    always_comb begin
        // terminal count per code; code 2 alternates 2- and 3-tick periods
        case (code)
            PRE_W'(1): last = CNT_W'(1);
            PRE_W'(2): last = s_q.phase ? CNT_W'(2) : CNT_W'(1);
            PRE_W'(3): last = CNT_W'(2);
            default:   last = CNT_W'(1);
        endcase
        tick = adv && (s_q.cnt == last);

        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (tick) begin
            s_d.cnt = '0;
            if (code == PRE_W'(2)) s_d.phase = !s_q.phase;
        end else if (adv) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: the count never reaches the unused value 3
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt != CNT_W'(3));

    // R2: in the 2.5 mode each predivider period flips the long/short phase
    p_phase_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && code == PRE_W'(2)) |=> (s_q.phase != $past(s_q.phase)));
endmodule

// File: rtl/fcg_intdiv.sv
module fcg_intdiv
    import fcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_next,
    input  logic             adv,
    input  logic [DIV_W-1:0] div,
    output logic             wrap,
    output logic             hi_next,
    output logic [DIV_W-1:0] cnt_o,
    output logic             out_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             out;
    } div_st_t;

    div_st_t          s_q, s_d;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt_nom;

    always_comb begin
        half    = div >> 1;
        wrap    = adv && (s_q.cnt == div - DIV_W'(1));
        if (wrap)     cnt_nom = '0;
        else if (adv) cnt_nom = s_q.cnt + DIV_W'(1);
        else          cnt_nom = s_q.cnt;
        hi_next = cnt_nom < half;

        s_d     = s_q;
        s_d.cnt = run_next ? cnt_nom : '0;
        s_d.out = run_next && hi_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign out_o = s_q.out;

    // R4: the output falls only on a predivider period edge
    p_fall_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.out) |-> $past(adv));

    // R7: every rising edge begins a fresh output period
    p_rise_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.out) |-> (s_q.cnt == '0));
endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen
    import fcg_pkg::*;
#(
    parameter int REF_N = NUM_REF,
    parameter int WORD_W = CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REF_N-1:0]  ref_tick,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              clk_out
);
    typedef struct packed {
        clk_cfg_t cfg;
        clk_cfg_t act;
        logic     run;
    } top_st_t;

    top_st_t          s_q, s_d;
    logic             sel_tick;
    logic             adv;
    logic             pre_tick;
    logic             wrap;
    logic             hi_next;
    logic [DIV_W-1:0] div_cmp;
    logic [DIV_W-1:0] div_cnt;

    always_comb begin
        if (!s_q.act.esel)    sel_tick = ref_tick[0];
        else if (s_q.act.psel) sel_tick = ref_tick[2];
        else                   sel_tick = ref_tick[1];
        adv     = s_q.run && sel_tick;
        // when idle the divider previews the stored word for the first phase
        div_cmp = s_q.run ? s_q.act.div : s_q.cfg.div;

        s_d = s_q;
        if (cfg_wr) s_d.cfg = clk_cfg_t'(cfg_wdata);

        if (!s_q.run || wrap) begin
            s_d.run = cfg_valid(s_q.cfg);
            s_d.act = s_q.cfg;
        end else if (!s_q.cfg.en && !hi_next) begin
            s_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    fcg_prediv u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!s_d.run),
        .adv   (adv),
        .code  (s_q.act.pdiv),
        .tick  (pre_tick)
    );

    fcg_intdiv u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_next (s_d.run),
        .adv      (pre_tick),
        .div      (div_cmp),
        .wrap     (wrap),
        .hi_next  (hi_next),
        .cnt_o    (div_cnt),
        .out_o    (clk_out)
    );

    // R5: a running divider always holds a legal configuration
    p_act_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> cfg_valid(s_q.act));

    // R3: the period counter stays below the active divisor
    p_cnt_lt_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (div_cnt < s_q.act.div));

    // R7: active settings change only across a period boundary
    p_act_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && $past(s_q.run) && !$past(wrap)) |-> $stable(s_q.act));

    // R8: an idle generator drives its output low
    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.run |-> !clk_out);
endmodule

// File: tb/frac_clkgen_tb.sv
`timescale 1ns/1ps
module frac_clkgen_tb_top;
    localparam int NV = 10;

    function automatic int mk(input int en, input int es, input int ps,
                              input int pd, input int dv);
        return (en << 11) | (es << 10) | (ps << 9) | (pd << 7) | dv;
    endfunction

    // reference spacing: src0 every cycle, src1 every 2nd, src2 every 3rd
    localparam int VEC_CFG [NV] = '{
        mk(1,0,0,1,8),   mk(1,0,0,3,5),   mk(1,0,0,2,4),   mk(1,1,0,2,3),
        mk(1,1,1,3,2),   mk(1,0,1,1,3),   mk(1,0,0,1,127), mk(1,1,1,3,127),
        mk(1,1,1,2,7),   mk(1,1,0,1,2)};
    localparam int VEC_PAIR [NV] = '{32, 30, 20, 30, 36, 12, 508, 2286, 105, 16};
    localparam int VEC_HIGH [NV] = '{8, 6, 0, 0, 9, 2, 126, 567, 0, 4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ref_tick = '0;
    logic [2:0]  tick_en = 3'b111;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_wdata = '0;
    logic        clk_out;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    frac_clkgen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .clk_out   (clk_out)
    );

    initial forever begin
        @(negedge clk);
        cyc++;
        ref_tick[0] = tick_en[0];
        ref_tick[1] = tick_en[1] && (cyc % 2 == 0);
        ref_tick[2] = tick_en[2] && (cyc % 3 == 0);
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int w);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = 12'(w);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_out(input logic v, output int t);
        t = -100000;
        for (int n = 0; n < 6000; n++) begin
            @(negedge clk);
            if (clk_out === v) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic next_rise(output int t);
        int tmp;
        wait_out(1'b0, tmp);
        wait_out(1'b1, t);
    endtask

    task automatic low_for(input int n, output int highs);
        highs = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (clk_out !== 1'b0) highs++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int r1, f1, r2, r3, f2, h, t0;
        logic v0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: output low out of reset with the zero (disabled) word
        low_for(40, h);
        check(h == 0, "R9 reset low", h, 0);

        // R1 R2 R3 R4 R6: table of source/predivider/divisor combinations
        for (int i = 0; i < NV; i++) begin
            wr(VEC_CFG[i]);
            next_rise(t0);
            next_rise(t0);
            next_rise(r1);
            wait_out(1'b0, f1);
            wait_out(1'b1, r2);
            next_rise(r3);
            check((r3 - r1) == VEC_PAIR[i], "R1/R2/R3/R6 pair period", r3 - r1, VEC_PAIR[i]);
            if (VEC_HIGH[i] != 0)
                check((f1 - r1) == VEC_HIGH[i], "R4 high width", f1 - r1, VEC_HIGH[i]);
        end

        // R5: invalid settings keep the output low
        wr(0);
        wait_out(1'b0, t0);
        repeat (20) @(negedge clk);
        wr(mk(1,0,0,0,8));
        low_for(300, h);
        check(h == 0, "R5 predivider code 0", h, 0);
        wr(mk(1,0,0,1,1));
        low_for(300, h);
        check(h == 0, "R5 divisor 1", h, 0);
        wr(mk(1,0,0,3,0));
        low_for(300, h);
        check(h == 0, "R5 divisor 0", h, 0);

        // R8 R6: clearing enable mid-high finishes the high phase
        wr(mk(1,0,0,1,8));
        next_rise(t0);
        next_rise(r1);
        repeat (2) @(negedge clk);
        wr(mk(0,0,0,1,8));
        wait_out(1'b0, f1);
        check((f1 - r1) == 8, "R8 high completes", f1 - r1, 8);
        low_for(200, h);
        check(h == 0, "R8 stays low", h, 0);
        wr(mk(1,0,0,1,8));
        wait_out(1'b1, r1);
        wait_out(1'b0, f1);
        check((f1 - r1) == 8, "R8 restart full width", f1 - r1, 8);

        // R7: mid-period reconfiguration waits for the boundary
        wr(mk(1,0,0,3,100));
        next_rise(t0);
        next_rise(t0);
        next_rise(r1);
        repeat (5) @(negedge clk);
        wr(mk(1,0,0,1,2));
        wait_out(1'b0, f1);
        wait_out(1'b1, r2);
        check((f1 - r1) == 150, "R7 old high kept", f1 - r1, 150);
        check((r2 - r1) == 300, "R7 old period kept", r2 - r1, 300);
        wait_out(1'b0, f2);
        wait_out(1'b1, r3);
        check((r3 - r2) == 4, "R7 new period", r3 - r2, 4);

        // R1: stopping the selected reference freezes the output
        // while the other two references keep ticking
        wr(mk(1,1,1,1,2));
        next_rise(t0);
        next_rise(t0);
        @(negedge clk);
        tick_en[2] = 1'b0;
        @(negedge clk);
        v0 = clk_out;
        h = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (clk_out !== v0) h++;
        end
        check(h == 0, "R1 unselected ticks ignored", h, 0);
        tick_en[2] = 1'b1;
        next_rise(r1);
        next_rise(r2);
        check((r2 - r1) == 12, "R1 resumes on own ticks", r2 - r1, 12);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule